// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits on the controller side of an asynchronous DRAM that has no clock of its own. After system reset it holds every memory strobe inactive for the power-up pause. It then runs a series of warm-up cycles and raises a ready flag. From then on it issues CAS-before-RAS refresh cycles often enough that all 512 rows are refreshed within each 8 ms window. The DRAM steps its own internal row counter on each of these cycles, so the block never produces an address.

The block shares the strobes with a data-access engine through an arbiter, using a level handshake. It raises a request and holds it until the arbiter grants the strobes. It then drives RAS, both CAS lines and WE itself, runs every pending refresh back to back, and ends with a one-cycle done pulse. Refresh ticks that arrive while the grant is withheld are counted in a saturating backlog. While it owns the strobes it raises a quiet flag, which tells the datapath to leave the data bus undriven and unsampled. All timing minimums are given in clock cycles. The pause length and the refresh interval are derived from the clock-frequency parameter.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, ras_n, lcas_n, ucas_n and we_n are 1, and ref_req, ref_done, ready, backlog_ovf and bus_quiet are 0.
- R2: After reset is released, all strobes stay 1 and ref_req stays 0 for exactly PAUSE clock cycles, where PAUSE = ceil(CLK_HZ x 200 us). ref_req is 1 in the cycle that follows.
- R3: Exactly INIT_CYC (default 8) refresh cycles are issued before ready rises. ready rises in the same cycle as the ref_done that ends them, and it never falls again until reset.
- R4: Each refresh cycle is CAS-before-RAS. lcas_n and ucas_n are always equal. They fall exactly T_CSR cycles before ras_n falls, stay 0 while ras_n is 0, and rise together with ras_n.
- R5: ras_n stays 0 for exactly T_RAS cycles in every refresh cycle. Between two cycles of one burst, ras_n stays 1 for exactly T_RP + T_CSR cycles.
- R6: we_n is 1 at all times.
- R7: A strobe is 0 only while ref_gnt and ref_req are both 1. Once raised, ref_req stays 1 until the cycle in which ref_done is 1.
- R8: ref_done is a single-cycle pulse at the end of each burst, and ref_req is 0 in that cycle.
- R9: Once ready is 1, a refresh tick occurs every INTERVAL = floor(CLK_HZ / 64000) cycles. The first request after initialization appears INTERVAL cycles after ready rises.
- R10: Ticks that arrive without a grant accumulate up to BACKLOG_MAX (default 8). When granted, the block issues min(ticks, BACKLOG_MAX) refresh cycles back to back in one burst.
- R11: backlog_ovf becomes 1 when a tick arrives with the backlog already at BACKLOG_MAX, and it stays 1 until reset.
- R12: bus_quiet is 1 in every cycle in which any strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant; level, held while ref_req is 1 |
| ref_req | output | 1 | Refresh request to the arbiter; level |
| ref_done | output | 1 | One-cycle pulse when a burst ends |
| ready | output | 1 | Initialization complete; memory may be used |
| backlog_ovf | output | 1 | Sticky flag: a tick was lost at a full backlog |
| bus_quiet | output | 1 | Block owns the strobes; data bus must be left undriven |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low; held inactive |

## Verification
The checks assume that the arbiter follows the handshake. It raises ref_gnt only while ref_req is 1, keeps it high until ref_done, and lowers it afterwards before granting again. Under that assumption, a strobe that moves without a grant points to a fault in the block. The stimulus acts as such an arbiter. It changes ref_gnt only on falling clock edges, grants only after it sees a request, and releases the grant the cycle after the done pulse. It withholds grants for a sweep of whole tick counts, from one tick up to beyond the backlog limit.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CSR,
    ST_RASL,
    ST_PRE,
    ST_REL
  } rf_state_e;

  // 8 ms / 512 rows = 15.625 us = 1/64000 s per refresh slot
  function automatic int interval_cyc(input longint clk_hz);
    return int'(clk_hz / 64000);
  endfunction

  // 200 us power-up pause, rounded up to whole cycles
  function automatic int pause_cyc(input longint clk_hz);
    return int'((clk_hz * 200 + 999_999) / 1_000_000);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic ovf
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend;
  logic          full;

  assign full    = (pend == PW'(MAX_PEND));
  assign nonzero = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ovf  <= 1'b0;
    end else begin
      unique case ({inc, dec})
        2'b10: begin
          if (full) ovf  <= 1'b1;
          else      pend <= pend + 1'b1;
        end
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_strobe_fsm.sv
module rfsh_strobe_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE    = 20000,
  parameter int INIT_CYC = 8,
  parameter int T_CSR    = 2,
  parameter int T_RAS    = 4,
  parameter int T_RP     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic work,
  input  logic gnt,
  output logic ras_n,
  output logic cas_n,
  output logic req,
  output logic done,
  output logic ready,
  output logic quiet,
  output logic take,
  output logic cyc_start
);
  localparam int TW = $clog2(max4(PAUSE, T_CSR, T_RAS, T_RP) + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  rf_state_e     state;
  logic [TW-1:0] tmr;
  logic [IW-1:0] init_left;
  logic          have_work, tmr_end, burst_end;

  assign have_work = (init_left != '0) || work;
  assign tmr_end   = (tmr == '0);
  assign cyc_start = (state == ST_IDLE && have_work && gnt) ||
                     (state == ST_PRE && tmr_end && have_work);
  assign burst_end = (state == ST_PRE) && tmr_end && !have_work;
  assign take      = cyc_start && (init_left == '0);

  assign cas_n = !(state == ST_CSR || state == ST_RASL);
  assign ras_n = !(state == ST_RASL);
  assign quiet = (state == ST_CSR) || (state == ST_RASL) || (state == ST_PRE);
  assign req   = quiet || (state == ST_IDLE && have_work);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PAUSE;
      tmr       <= TW'(PAUSE - 1);
      init_left <= IW'(INIT_CYC);
      done      <= 1'b0;
      ready     <= 1'b0;
    end else begin
      done <= burst_end;
      if (burst_end) ready <= 1'b1;
      if (cyc_start && init_left != '0) init_left <= init_left - 1'b1;
      if (!tmr_end) tmr <= tmr - 1'b1;
      unique case (state)
        ST_PAUSE: if (tmr_end) state <= ST_IDLE;
        ST_IDLE: if (cyc_start) begin
          state <= ST_CSR;
          tmr   <= TW'(T_CSR - 1);
        end
        ST_CSR: if (tmr_end) begin
          state <= ST_RASL;
          tmr   <= TW'(T_RAS - 1);
        end
        ST_RASL: if (tmr_end) begin
          state <= ST_PRE;
          tmr   <= TW'(T_RP - 1);
        end
        ST_PRE: if (tmr_end) begin
          if (have_work) begin
            state <= ST_CSR;
            tmr   <= TW'(T_CSR - 1);
          end else begin
            state <= ST_REL;
          end
        end
        ST_REL:  if (!gnt) state <= ST_IDLE;
        default: state <= ST_PAUSE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int INIT_CYC    = 8,
  parameter int BACKLOG_MAX = 8,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_done,
  output logic ready,
  output logic backlog_ovf,
  output logic bus_quiet,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n
);
  localparam int INTERVAL = interval_cyc(longint'(CLK_HZ));
  localparam int PAUSE    = pause_cyc(longint'(CLK_HZ));

  logic iv_tick, cyc_take, cyc_start, has_work, cas_n;

  rfsh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(ready), .tick(iv_tick)
  );

  rfsh_backlog #(.MAX_PEND(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .inc(iv_tick), .dec(cyc_take),
    .nonzero(has_work), .ovf(backlog_ovf)
  );

  rfsh_strobe_fsm #(
    .PAUSE(PAUSE), .INIT_CYC(INIT_CYC),
    .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .work(has_work), .gnt(ref_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .req(ref_req), .done(ref_done),
    .ready(ready), .quiet(bus_quiet), .take(cyc_take), .cyc_start(cyc_start)
  );

  assign lcas_n = cas_n;
  assign ucas_n = cas_n;
  assign we_n   = 1'b1;
endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk #(
  parameter int T_RAS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_done,
  input logic ready,
  input logic backlog_ovf,
  input logic bus_quiet,
  input logic ras_n,
  input logic lcas_n,
  input logic iv_tick,
  input logic cyc_start
);
  logic [7:0] ras_run;

  always_ff @(posedge clk) begin
    if (!rst_n || ras_n) ras_run <= '0;
    else if (ras_run != 8'hFF) ras_run <= ras_run + 1'b1;
  end

  p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!lcas_n && $past(!lcas_n)));
  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_run == 8'(T_RAS)));
  p_gnt_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n) |-> (ref_gnt && ref_req));
  p_start_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> ref_gnt);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);
  p_done_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> !ref_req);
  p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ready);
  p_tick_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iv_tick |-> ready);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(backlog_ovf) |-> backlog_ovf);
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n) |-> bus_quiet);
endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk #(.T_RAS(T_RAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_done(ref_done), .ready(ready), .backlog_ovf(backlog_ovf),
  .bus_quiet(bus_quiet), .ras_n(ras_n), .lcas_n(lcas_n),
  .iv_tick(iv_tick), .cyc_start(cyc_start)
);

// File: tb/dram_rfsh_seq_bench.sv
module dram_rfsh_seq_bench;
  localparam int CLK_HZ = 12_800_000;
  localparam int NINIT  = 8;
  localparam int BMAX   = 8;
  localparam int TCSR   = 2;
  localparam int TRAS   = 4;
  localparam int TRP    = 3;
  // 12.8 MHz: 15.625 us slot and 200 us pause, restated in whole cycles
  localparam int EXP_INT   = (CLK_HZ / 1000) * 8 / 512;
  localparam int EXP_PAUSE = (CLK_HZ / 10000) * 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_done, ready, backlog_ovf, bus_quiet;
  logic ras_n, lcas_n, ucas_n, we_n;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dram_rfsh_seq #(
    .CLK_HZ(CLK_HZ), .INIT_CYC(NINIT), .BACKLOG_MAX(BMAX),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dram_rfsh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_done(ref_done), .ready(ready), .backlog_ovf(backlog_ovf),
    .bus_quiet(bus_quiet), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Passive monitor, sampled on the falling edge
  int ras_falls = 0;
  int cas_run = 0, ras_low = 0, ras_high = 0;
  bit prev_ras = 1'b1, prev_req = 1'b0, in_burst = 1'b0;
  int bad_r4 = 0, bad_r5 = 0, bad_r6 = 0, bad_r7 = 0, bad_r12 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) bad_r6++;
      if (lcas_n != ucas_n) bad_r4++;
      if ((!ras_n || !lcas_n) && !(ref_gnt && ref_req)) bad_r7++;
      if ((!ras_n || !lcas_n) && !bus_quiet) bad_r12++;
      if (prev_req && !ref_req && !ref_done) bad_r7++;
      if (prev_ras && !ras_n) begin
        ras_falls++;
        if (cas_run != TCSR) bad_r4++;
        if (in_burst && ras_high != TRP + TCSR) bad_r5++;
      end
      if (!prev_ras && ras_n) begin
        if (ras_low != TRAS) bad_r5++;
        if (!lcas_n) bad_r4++;
        in_burst = 1'b1;
      end
      if (!ras_n && lcas_n) bad_r4++;
      if (ref_done) in_burst = 1'b0;
      cas_run  = lcas_n ? 0 : cas_run + 1;
      ras_low  = ras_n ? 0 : ras_low + 1;
      ras_high = ras_n ? ras_high + 1 : 0;
      prev_ras = ras_n;
      prev_req = ref_req;
    end
  end

  task automatic run_burst(output int pulses);
    int start;
    start = ras_falls;
    ref_gnt = 1'b1;
    while (!ref_done) @(negedge clk);
    pulses = ras_falls - start;
  endtask

  initial begin
    int cnt, pulses, exp_n;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(ras_n && lcas_n && ucas_n && we_n, "R1 strobes high in reset", {ras_n, lcas_n, ucas_n, we_n}, 15);
    check(!ref_req && !ref_done && !ready && !backlog_ovf && !bus_quiet,
          "R1 flags low in reset", {ref_req, ref_done, ready, backlog_ovf, bus_quiet}, 0);
    rst_n = 1'b1;
    // R2 pause length
    cnt = 0;
    while (!ref_req && cnt < EXP_PAUSE + 10) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == EXP_PAUSE, "R2 pause cycles before first request", cnt, EXP_PAUSE);
    check(ras_falls == 0, "R2 no strobe activity during pause", ras_falls, 0);
    // R3 initialization burst
    run_burst(pulses);
    check(pulses == NINIT, "R3 init refresh cycles", pulses, NINIT);
    check(ready == 1'b1, "R3 ready with init done", ready, 1);
    check(ref_req == 1'b0, "R8 request low at done", ref_req, 0);
    @(negedge clk);
    ref_gnt = 1'b0;
    check(ref_done == 1'b0, "R8 done is one cycle", ref_done, 0);
    // R9 first tick interval, counted from the cycle ready rose
    cnt = 1;
    while (!ref_req && cnt < EXP_INT + 10) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == EXP_INT, "R9 first request after ready", cnt, EXP_INT);
    // R10/R11 backlog sweep: withhold grant for m further ticks
    for (int m = 0; m <= 9; m++) begin
      while (!ref_req) @(negedge clk);
      repeat (m * EXP_INT + EXP_INT / 2) @(negedge clk);
      check(ref_req == 1'b1, "R7 request held while ungranted", ref_req, 1);
      check(backlog_ovf == (m >= BMAX), "R11 overflow flag", backlog_ovf, (m >= BMAX));
      run_burst(pulses);
      exp_n = (m + 1 < BMAX) ? m + 1 : BMAX;
      check(pulses == exp_n, "R10 refresh cycles in burst", pulses, exp_n);
      check(ready == 1'b1, "R3 ready stays high", ready, 1);
      @(negedge clk);
      ref_gnt = 1'b0;
      check(ref_done == 1'b0, "R8 done pulse width", ref_done, 0);
    end
    check(backlog_ovf == 1'b1, "R11 overflow sticky", backlog_ovf, 1);
    check(bad_r4 == 0, "R4 CAS-before-RAS ordering", bad_r4, 0);
    check(bad_r5 == 0, "R5 RAS low and precharge widths", bad_r5, 0);
    check(bad_r6 == 0, "R6 write enable held high", bad_r6, 0);
    check(bad_r7 == 0, "R7 strobes only under grant", bad_r7, 0);
    check(bad_r12 == 0, "R12 bus quiet during strobes", bad_r12, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule